// File: doc/BRIEF.md
# I2C Master Byte Controller

This block is a register-driven master for an I2C bus. It is meant to sit behind a small microcontroller-style write port. Software programs a control register and a data register. The block then does the bus work: it forms a start condition and clocks out an address byte or a data word, MSB first. When enabled, it adds the acknowledge clock. After each word it parks the bus with SCL held low and raises a one-cycle interrupt request.

Software reads five status outputs: a bus-busy flag, a pending flag, a master flag, a transmitter flag and the last acknowledge bit received. From these it decides what to do next. It can send another word, or it can order a stop condition. The first byte after a start carries a 7-bit address followed by a direction bit. For example, 0xCB encodes address 0x65 with the read direction. If a read-direction address is acknowledged, the transmitter flag clears by itself, so the next word is received.

Both lines are open-drain. Each line has an output enable that pulls it low. SDA also has an input sample, which the block reads for received data and for acknowledges. SCL comes from a divider of the system clock, and each SCL half period lasts `SCL_HALF` clock cycles. Slave mode, arbitration and clock stretching by slaves are not part of this block.

Top module: `i2c_word_master`

## Requirements
- R1: After reset every flag reads 0, irq is 0, the data register is 0, and both output enables are 0 (both lines released).
- R2: A data write (wrAddr=1) while the bus is idle only loads the data register. No line moves, and busBusy and pendFlag stay 0.
- R3: A control write with wrData[7:4]=4'b1111 while busBusy is 0 starts a transfer. In the next cycle busBusy, masterFlag, xmitFlag and pendFlag are all 1. SDA is then pulled low with SCL released for SCL_HALF cycles. Next, both lines are pulled low for SCL_HALF cycles. After that, the byte already held in the data register is sent.
- R4: Each bit takes SCL_HALF cycles with SCL pulled low, then SCL_HALF cycles with SCL released. Bits go out MSB first. When transmitting, sdaOe is the inverse of the bit. When receiving, SDA stays released, and the line is sampled at the end of the released half and shifted in at the LSB. dataOut shows the shift register, so after a transmitted word it holds the value read back from the line.
- R5: Control bits [2:0] give the word length: 0 means 8 bits, and 1..7 mean that many bits. The length is taken when a word is armed, so it must be written before the word it applies to.
- R6: Control bit 3 enables the acknowledge slot, one extra SCL pulse after the last bit. A transmitter releases SDA in this slot and stores the sampled line in lastRxBit. A receiver pulls SDA low. With bit 3 at 0 there is no slot, and lastRxBit keeps its value.
- R7: When a word ends, pendFlag goes to 0 and SCL stays pulled low with SDA released. irq is 1 for exactly the first cycle of this hold.
- R8: A data write during the hold loads the register, sets pendFlag, and starts the first bit's SCL-low half in the next cycle.
- R9: xmitFlag clears to 0 at the end of the first word after a start, but only if that word's last bit was 1 and the acknowledge was sampled as 0. Later words, a direction bit of 0, or a missing acknowledge leave it unchanged.
- R10: A control write with wrData[7:4]=4'b1101 during the hold produces a stop in three stages of SCL_HALF cycles each. First both lines are pulled low. Then SCL is released while SDA stays low. Then both lines are released. After that busBusy, masterFlag and pendFlag read 0.
- R11: The following writes are ignored: a start command while busBusy is 1, a stop command while idle, and any data write while a start, a word or a stop is running.
- R12: With SCL released on two consecutive cycles, SDA does not change, except when a start begins or a stop releases SDA.
- R13: A control write that is neither a start nor a stop updates only the acknowledge enable and the word length. It has no effect on the lines or on any flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 1 | 0 selects control, 1 selects data |
| wrData | input | 8 | Write data |
| sdaIn | input | 1 | Sampled SDA line level |
| sclOe | output | 1 | 1 pulls SCL low |
| sdaOe | output | 1 | 1 pulls SDA low |
| busBusy | output | 1 | Bus owned between start and stop |
| pendFlag | output | 1 | Sequence in progress; 0 while parked |
| masterFlag | output | 1 | 1 while operating as master |
| xmitFlag | output | 1 | 1 when transmitting, 0 when receiving |
| lastRxBit | output | 1 | Last sampled acknowledge |
| irq | output | 1 | One-cycle pulse at word end |
| dataOut | output | 8 | Data/shift register contents |

## Verification
The assertions assume that sdaIn follows the wired-AND of the block's own drive and a slave's drive. They also assume that the slave changes its drive only while SCL is pulled low. The bench models the line as exactly that AND. Its slave changes its pull-down only at the start of an SCL-low half. Writes are held for one clock and placed on negative edges. Some writes are deliberately misplaced, either during a running word or while the bus is idle or busy, so that the ignore rules are exercised. The reset-time flags, the line sequencing and R12 stay within the assertions' assumptions.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
  localparam int WORD_W  = 8;
  localparam int BC_W    = $clog2(WORD_W);
  localparam int LEFT_W  = BC_W + 1;
  localparam int ACK_POS = BC_W;
  localparam int CMD_W   = 4;
  localparam logic [CMD_W-1:0] CMD_START = 4'b1111;
  localparam logic [CMD_W-1:0] CMD_STOP  = 4'b1101;

  typedef enum logic [3:0] {
    S_IDLE, S_STA_A, S_STA_B, S_BIT_LO, S_BIT_HI,
    S_ACK_LO, S_ACK_HI, S_HOLD, S_STO_A, S_STO_B, S_STO_C
  } phase_e;

  typedef struct packed {
    logic              load;
    logic              arm;
    logic              shift;
    logic [LEFT_W-1:0] armBits;
  } dpCtl_t;
endpackage

// File: rtl/i2cm_phase_timer.sv
module i2cm_phase_timer #(
  parameter int SCL_HALF = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic run,
  output logic phaseEnd
);
  localparam int CW = (SCL_HALF > 1) ? $clog2(SCL_HALF) : 1;
  localparam logic [CW-1:0] LAST = CW'(SCL_HALF - 1);

  logic [CW-1:0] cnt;

  assign phaseEnd = run && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rstN || !run || phaseEnd) cnt <= '0;
    else cnt <= cnt + 1'b1;
  end

  a_r4_count_bound: assert property (@(posedge clk) disable iff (!rstN)
    cnt <= LAST);
endmodule

// File: rtl/i2cm_datapath.sv
module i2cm_datapath import i2cm_pkg::*; (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  input  logic [WORD_W-1:0] wrData,
  input  logic              sdaIn,
  output logic              txBit,
  output logic              lastBit,
  output logic [WORD_W-1:0] dataOut
);
  logic [WORD_W-1:0] shiftReg;
  logic [LEFT_W-1:0] bitsLeft;

  assign txBit   = shiftReg[WORD_W-1];
  assign lastBit = (bitsLeft == LEFT_W'(1));
  assign dataOut = shiftReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg <= '0;
      bitsLeft <= '0;
    end else begin
      if (ctl.load)  shiftReg <= wrData;
      if (ctl.arm)   bitsLeft <= ctl.armBits;
      if (ctl.shift) begin
        shiftReg <= {shiftReg[WORD_W-2:0], sdaIn};
        bitsLeft <= bitsLeft - 1'b1;
      end
    end
  end

  // R5: word length stays within the register width
  a_r5_left_range: assert property (@(posedge clk) disable iff (!rstN)
    bitsLeft <= LEFT_W'(WORD_W));
  // R4: a shift only happens while bits remain
  a_r4_shift_has_bits: assert property (@(posedge clk) disable iff (!rstN)
    ctl.shift |-> bitsLeft != '0);
endmodule

// File: rtl/i2cm_control.sv
module i2cm_control import i2cm_pkg::*; (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              wrAddr,
  input  logic [WORD_W-1:0] wrData,
  input  logic              sdaIn,
  input  logic              phaseEnd,
  input  logic              txBit,
  input  logic              lastBit,
  output logic              run,
  output dpCtl_t            dpCtl,
  output logic              sclOe,
  output logic              sdaOe,
  output logic              busBusy,
  output logic              pendFlag,
  output logic              masterFlag,
  output logic              xmitFlag,
  output logic              lastRxBit,
  output logic              irq
);
  phase_e            state;
  logic [BC_W-1:0]   bitCntQ;
  logic              ackEnQ, firstWordQ, dirBitQ;
  logic [CMD_W-1:0]  cmd;
  logic              wrCtl, wrDat, parked;
  logic              startReq, stopReq, cfgWr, dataGo, dataLoad;

  function automatic logic [LEFT_W-1:0] wordLen(input logic [BC_W-1:0] bc);
    return (bc == '0) ? LEFT_W'(WORD_W) : LEFT_W'(bc);
  endfunction

  always_comb begin
    cmd      = wrData[WORD_W-1 -: CMD_W];
    wrCtl    = wrEn && !wrAddr;
    wrDat    = wrEn && wrAddr;
    parked   = (state == S_IDLE) || (state == S_HOLD);
    startReq = wrCtl && (cmd == CMD_START) && !busBusy;
    stopReq  = wrCtl && (cmd == CMD_STOP) && (state == S_HOLD);
    cfgWr    = wrCtl && (cmd != CMD_START) && (cmd != CMD_STOP) && parked;
    dataGo   = wrDat && (state == S_HOLD);
    dataLoad = wrDat && parked;
    run      = !parked;
    dpCtl.load    = dataLoad;
    dpCtl.arm     = startReq || dataGo;
    dpCtl.shift   = (state == S_BIT_HI) && phaseEnd;
    dpCtl.armBits = startReq ? wordLen(wrData[BC_W-1:0]) : wordLen(bitCntQ);
  end

  always_comb begin
    sclOe = 1'b0;
    sdaOe = 1'b0;
    case (state)
      S_STA_A:  sdaOe = 1'b1;
      S_STA_B:  begin sclOe = 1'b1; sdaOe = 1'b1; end
      S_BIT_LO: begin sclOe = 1'b1; sdaOe = xmitFlag && !txBit; end
      S_BIT_HI: sdaOe = xmitFlag && !txBit;
      S_ACK_LO: begin sclOe = 1'b1; sdaOe = !xmitFlag; end
      S_ACK_HI: sdaOe = !xmitFlag;
      S_HOLD:   sclOe = 1'b1;
      S_STO_A:  begin sclOe = 1'b1; sdaOe = 1'b1; end
      S_STO_B:  sdaOe = 1'b1;
      default:  ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= S_IDLE;
      busBusy    <= 1'b0;
      pendFlag   <= 1'b0;
      masterFlag <= 1'b0;
      xmitFlag   <= 1'b0;
      lastRxBit  <= 1'b0;
      irq        <= 1'b0;
      bitCntQ    <= '0;
      ackEnQ     <= 1'b0;
      firstWordQ <= 1'b0;
      dirBitQ    <= 1'b0;
    end else begin
      irq <= 1'b0;
      if (startReq) begin
        state      <= S_STA_A;
        busBusy    <= 1'b1;
        masterFlag <= 1'b1;
        xmitFlag   <= 1'b1;
        pendFlag   <= 1'b1;
        ackEnQ     <= wrData[ACK_POS];
        bitCntQ    <= wrData[BC_W-1:0];
        firstWordQ <= 1'b1;
      end else if (stopReq) begin
        state    <= S_STO_A;
        pendFlag <= 1'b1;
      end else if (dataGo) begin
        state    <= S_BIT_LO;
        pendFlag <= 1'b1;
      end else begin
        if (cfgWr) begin
          ackEnQ  <= wrData[ACK_POS];
          bitCntQ <= wrData[BC_W-1:0];
        end
        if (phaseEnd) begin
          case (state)
            S_STA_A:  state <= S_STA_B;
            S_STA_B:  state <= S_BIT_LO;
            S_BIT_LO: state <= S_BIT_HI;
            S_BIT_HI: begin
              if (lastBit) begin
                dirBitQ <= txBit;
                if (ackEnQ) state <= S_ACK_LO;
                else begin
                  state      <= S_HOLD;
                  pendFlag   <= 1'b0;
                  irq        <= 1'b1;
                  firstWordQ <= 1'b0;
                end
              end else state <= S_BIT_LO;
            end
            S_ACK_LO: state <= S_ACK_HI;
            S_ACK_HI: begin
              lastRxBit <= sdaIn;
              if (firstWordQ && xmitFlag && dirBitQ && !sdaIn) xmitFlag <= 1'b0;
              firstWordQ <= 1'b0;
              state      <= S_HOLD;
              pendFlag   <= 1'b0;
              irq        <= 1'b1;
            end
            S_STO_A:  state <= S_STO_B;
            S_STO_B:  state <= S_STO_C;
            S_STO_C: begin
              state      <= S_IDLE;
              busBusy    <= 1'b0;
              masterFlag <= 1'b0;
              pendFlag   <= 1'b0;
            end
            default: ;
          endcase
        end
      end
    end
  end

  // R12: SDA holds still while SCL stays released, outside start and stop edges
  a_r12_sda_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (!sclOe && !$past(sclOe) && !(state inside {S_STA_A, S_STO_C})) |-> $stable(sdaOe));
  // R7: interrupt is a single-cycle pulse
  a_r7_irq_pulse: assert property (@(posedge clk) disable iff (!rstN)
    irq |=> !irq);
  // R7: interrupt coincides with a parked bus
  a_r7_irq_parked: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (sclOe && !sdaOe && !pendFlag));
  // R3: the bus becomes busy with SDA low and SCL released
  a_r3_start_shape: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busBusy) |-> (sdaOe && !sclOe));
  // R10: the bus becomes free with both lines released
  a_r10_release: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busBusy) |-> (!sclOe && !sdaOe && !masterFlag));
  // R9: the transmitter flag only drops at the end of a word
  a_r9_xmit_drop: assert property (@(posedge clk) disable iff (!rstN)
    $fell(xmitFlag) |-> irq);
endmodule

// File: rtl/i2c_word_master.sv
module i2c_word_master import i2cm_pkg::*; #(
  parameter int SCL_HALF = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              wrAddr,
  input  logic [WORD_W-1:0] wrData,
  input  logic              sdaIn,
  output logic              sclOe,
  output logic              sdaOe,
  output logic              busBusy,
  output logic              pendFlag,
  output logic              masterFlag,
  output logic              xmitFlag,
  output logic              lastRxBit,
  output logic              irq,
  output logic [WORD_W-1:0] dataOut
);
  dpCtl_t dpCtl;
  logic   run, phaseEnd, txBit, lastBit;

  i2cm_phase_timer #(.SCL_HALF(SCL_HALF)) uTimer (
    .clk(clk), .rstN(rstN), .run(run), .phaseEnd(phaseEnd)
  );

  i2cm_control uCtl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .sdaIn(sdaIn), .phaseEnd(phaseEnd), .txBit(txBit), .lastBit(lastBit),
    .run(run), .dpCtl(dpCtl), .sclOe(sclOe), .sdaOe(sdaOe),
    .busBusy(busBusy), .pendFlag(pendFlag), .masterFlag(masterFlag),
    .xmitFlag(xmitFlag), .lastRxBit(lastRxBit), .irq(irq)
  );

  i2cm_datapath uDp (
    .clk(clk), .rstN(rstN), .ctl(dpCtl), .wrData(wrData), .sdaIn(sdaIn),
    .txBit(txBit), .lastBit(lastBit), .dataOut(dataOut)
  );
endmodule

// File: tb/tb_i2c_word_master.sv
module tb_i2c_word_master;
  localparam int H = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic wrAddr = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic slvLow = 1'b0;
  logic sdaIn, sclOe, sdaOe, busBusy, pendFlag, masterFlag, xmitFlag, lastRxBit, irq;
  logic [7:0] dataOut;
  int nCmp = 0;
  int nBad = 0;

  always #5 clk = ~clk;

  assign sdaIn = !(sdaOe || slvLow);

  i2c_word_master #(.SCL_HALF(H)) dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .sdaIn(sdaIn), .sclOe(sclOe), .sdaOe(sdaOe), .busBusy(busBusy),
    .pendFlag(pendFlag), .masterFlag(masterFlag), .xmitFlag(xmitFlag),
    .lastRxBit(lastRxBit), .irq(irq), .dataOut(dataOut)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    nCmp++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic pinPhase(input logic expScl, input logic expSda, input string tag);
    for (int k = 0; k < H; k++) begin
      chk({tag, " scl"}, {7'd0, sclOe}, {7'd0, expScl});
      chk({tag, " sda"}, {7'd0, sdaOe}, {7'd0, expSda});
      @(negedge clk);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic startSeq();
    pinPhase(1'b0, 1'b1, "R3 start-a");
    pinPhase(1'b1, 1'b1, "R3 start-b");
  endtask

  task automatic stopSeq();
    pinPhase(1'b1, 1'b1, "R10 stop-a");
    pinPhase(1'b0, 1'b1, "R10 stop-b");
    pinPhase(1'b0, 1'b0, "R10 stop-c");
  endtask

  // val: transmitted word (tx) or slave data (rx), MSB-first over n bits
  task automatic word(input logic [7:0] val, input int n, input logic tx,
                      input logic ack, input logic slvAck);
    for (int i = 0; i < n; i++) begin
      if (tx) begin
        slvLow = 1'b0;
        pinPhase(1'b1, !val[7-i], "R4 tx-lo");
        pinPhase(1'b0, !val[7-i], "R4 tx-hi");
      end else begin
        slvLow = !val[n-1-i];
        pinPhase(1'b1, 1'b0, "R4 rx-lo");
        pinPhase(1'b0, 1'b0, "R4 rx-hi");
      end
    end
    if (ack) begin
      slvLow = tx ? slvAck : 1'b0;
      pinPhase(1'b1, !tx, "R6 ack-lo");
      pinPhase(1'b0, !tx, "R6 ack-hi");
    end
    slvLow = 1'b0;
  endtask

  task automatic holdEntry();
    chk("R7 irq first hold cycle", {7'd0, irq}, 8'd1);
    chk("R7 pend cleared", {7'd0, pendFlag}, 8'd0);
    chk("R7 scl held", {7'd0, sclOe}, 8'd1);
    chk("R7 sda released", {7'd0, sdaOe}, 8'd0);
    @(negedge clk);
    chk("R7 irq one cycle", {7'd0, irq}, 8'd0);
  endtask

  task automatic quiet(input int n, input logic expScl, input string tag);
    for (int k = 0; k < n; k++) begin
      chk({tag, " scl"}, {7'd0, sclOe}, {7'd0, expScl});
      chk({tag, " sda"}, {7'd0, sdaOe}, 8'd0);
      @(negedge clk);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nBad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 busy", {7'd0, busBusy}, 8'd0);
    chk("R1 pend", {7'd0, pendFlag}, 8'd0);
    chk("R1 master", {7'd0, masterFlag}, 8'd0);
    chk("R1 xmit", {7'd0, xmitFlag}, 8'd0);
    chk("R1 lastrx", {7'd0, lastRxBit}, 8'd0);
    chk("R1 irq", {7'd0, irq}, 8'd0);
    chk("R1 data", dataOut, 8'h00);
    chk("R1 scl", {7'd0, sclOe}, 8'd0);
    chk("R1 sda", {7'd0, sdaOe}, 8'd0);

    // R2 data write while idle only loads
    wr(1'b1, 8'hCB);
    quiet(2 * H, 1'b0, "R2 idle lines");
    chk("R2 data loaded", dataOut, 8'hCB);
    chk("R2 busy", {7'd0, busBusy}, 8'd0);
    chk("R2 pend", {7'd0, pendFlag}, 8'd0);

    // R11 stop command while idle ignored
    wr(1'b0, 8'hD8);
    quiet(3 * H, 1'b0, "R11 stop idle");
    chk("R11 busy after idle stop", {7'd0, busBusy}, 8'd0);

    // R3 start, read-direction address 0xCB acked
    wr(1'b0, 8'hF8);
    chk("R3 busy", {7'd0, busBusy}, 8'd1);
    chk("R3 master", {7'd0, masterFlag}, 8'd1);
    chk("R3 xmit", {7'd0, xmitFlag}, 8'd1);
    chk("R3 pend", {7'd0, pendFlag}, 8'd1);
    startSeq();
    word(8'hCB, 8, 1'b1, 1'b1, 1'b1);
    holdEntry();
    chk("R6 lastrx ack", {7'd0, lastRxBit}, 8'd0);
    chk("R9 xmit cleared after read address", {7'd0, xmitFlag}, 8'd0);
    chk("R4 readback", dataOut, 8'hCB);
    quiet(H, 1'b1, "R7 hold");

    // R8 receive word 0x5A, master acks; R11 mid-word data write ignored
    wr(1'b1, 8'h00);
    chk("R8 pend set", {7'd0, pendFlag}, 8'd1);
    fork
      word(8'h5A, 8, 1'b0, 1'b1, 1'b0);
      begin
        repeat (6) @(negedge clk);
        wrEn = 1'b1; wrAddr = 1'b1; wrData = 8'hEE;
        @(negedge clk);
        wrEn = 1'b0;
      end
    join
    holdEntry();
    chk("R4 rx data", dataOut, 8'h5A);
    chk("R11 mid-word write ignored", dataOut, 8'h5A);

    // R13 config write: no ack, 3-bit words
    wr(1'b0, 8'h03);
    chk("R13 busy kept", {7'd0, busBusy}, 8'd1);
    chk("R13 master kept", {7'd0, masterFlag}, 8'd1);
    chk("R13 xmit kept", {7'd0, xmitFlag}, 8'd0);
    chk("R13 pend kept", {7'd0, pendFlag}, 8'd0);
    quiet(H, 1'b1, "R13 lines");

    // R5 three-bit receive without ack slot
    wr(1'b1, 8'h00);
    word(8'h05, 3, 1'b0, 1'b0, 1'b0);
    holdEntry();
    chk("R5 three-bit word", dataOut, 8'h05);
    chk("R6 lastrx unchanged", {7'd0, lastRxBit}, 8'd0);

    // R11 start while busy ignored
    wr(1'b0, 8'hF8);
    quiet(2 * H, 1'b1, "R11 start busy");
    chk("R11 pend after start busy", {7'd0, pendFlag}, 8'd0);

    // R10 stop
    wr(1'b0, 8'hD8);
    stopSeq();
    chk("R10 busy", {7'd0, busBusy}, 8'd0);
    chk("R10 master", {7'd0, masterFlag}, 8'd0);
    chk("R10 pend", {7'd0, pendFlag}, 8'd0);
    quiet(H, 1'b0, "R10 idle");

    // Second transfer: write-direction address, then a nacked data word
    wr(1'b1, 8'hA4);
    wr(1'b0, 8'hF8);
    startSeq();
    word(8'hA4, 8, 1'b1, 1'b1, 1'b1);
    holdEntry();
    chk("R9 xmit kept write address", {7'd0, xmitFlag}, 8'd1);
    wr(1'b1, 8'h37);
    word(8'h37, 8, 1'b1, 1'b1, 1'b0);
    holdEntry();
    chk("R6 lastrx nack", {7'd0, lastRxBit}, 8'd1);
    chk("R9 xmit kept later word", {7'd0, xmitFlag}, 8'd1);
    chk("R4 readback 2", dataOut, 8'h37);
    wr(1'b0, 8'hD8);
    stopSeq();
    chk("R10 busy 2", {7'd0, busBusy}, 8'd0);
    quiet(H, 1'b0, "R10 idle 2");

    summary();
    $finish;
  end
endmodule